// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers twelve interrupt sources and turns them into a single three-bit priority request for a processor. Each source has its own control register. The register holds a three-bit level, an enable bit and a pending flag. Hardware sources set their pending flag on a rising edge of their input, so an event is kept even while the source is masked. Two software sources are set by a register write. The abort source is fed by a pushbutton, and its register also shows the live level of the switch. A global enable bit in a general control register gates every request.

The block drives the highest active level on `irqLevel`. When the processor runs an acknowledge cycle for a level, the block returns an eight-bit vector. This vector is a programmable base plus the fixed index of the winning source at that level. If no source qualifies, the vector is the base plus 15. The acknowledge cycle does not clear the pending flag. Software clears it by writing a one to bit 7 of the source register.

Source indices, in fixed order: 0 power fail, 1 bus error, 2 abort, 3 serial, 4 ethernet, 5 SCSI port, 6 SCSI DMA, 7 printer, 8 timer 1, 9 timer 2, 10 software 1, 11 software 2.

Top module: `vic_top`

## Requirements
- R1: After reset, all pending flags, enables, levels, the global enable and the vector base are 0. `irqLevel` is 0, and every register reads 0 except bit 6 of the abort register.
- R2: A rising edge on `srcIn[i]` sets the pending flag of source i at the next clock edge. This holds for every hardware source except index 2. The flag is set whether or not the source or the global gate is enabled. A level held high sets the flag only once.
- R3: A write to source register i with bit 7 = 1 clears its pending flag. A write with bit 7 = 0 leaves the flag unchanged. If a new rising edge comes in the same cycle as the clear, the edge wins and the flag stays set.
- R4: Sources 10 and 11 ignore `srcIn`. A write to their register with bit 5 = 1 sets the pending flag. If the same write also has bit 7 = 1, the clear wins. Bit 5 always reads 0.
- R5: While bit 4 of register 12 (global enable) is 1, `irqLevel` equals the highest level among sources that are pending, enabled (bit 3) and at a nonzero level (bits 2:0). Otherwise `irqLevel` is 0.
- R6: When several qualifying sources share the acknowledged level, the one with the lowest index supplies the vector.
- R7: While `ackValid` is 1, `ackVector` equals register 13 (the base) plus the index of the winning qualifying source at `ackLevel`. While `ackValid` is 0, `ackVector` is 0.
- R8: An acknowledge with no qualifying source at `ackLevel` returns base + 15. This includes level 0 and the case where the global enable is off.
- R9: An acknowledge cycle leaves every pending flag unchanged.
- R10: Bit 6 of register 2 reads the live `abortSw` level. The abort pending flag is set on a rising edge of `abortSw`. `srcIn[2]` is ignored.
- R11: Registers 0 to 11 store only bits 3:0 and return pending in bit 7. Register 12 stores only bit 4. Register 13 stores all eight bits. Any other address reads 0 and ignores writes.
- R12: The vector sum wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 12 | Hardware source inputs, rising-edge sensitive |
| abortSw | input | 1 | Live level of the abort pushbutton |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| ackValid | input | 1 | Interrupt-acknowledge cycle in progress |
| ackLevel | input | 3 | Level being acknowledged |
| ackVector | output | 8 | Returned vector |
| irqLevel | output | 3 | Highest active request level |

## Verification
The bench targets several corner cases:
- An edge that arrives in the same cycle as a clear. A design that let the clear win would lose that event.
- Sources that are pending but disabled or at level 0. Letting them through would raise `irqLevel` or steer the vector.
- Two sources tied at one level. A design with the tie reversed would return the higher index.
- An acknowledge at an empty level, and a base near 255. A wrong spurious offset or a carry out of eight bits would show in `ackVector`.

It also confirms that an acknowledge leaves the flags set, and that a held-high input does not re-arm after a clear.

// File: rtl/vic_pkg.sv
package vic_pkg;
  parameter int NSRC      = 12;
  parameter int LVL_W     = 3;
  parameter int DATA_W    = 8;
  parameter int ADDR_W    = 5;
  parameter int ABORT_IDX = 2;
  parameter int SWA_IDX   = 10;
  parameter int SWB_IDX   = 11;
  parameter int SPUR_OFS  = 15;
  localparam int REG_GEN  = NSRC;
  localparam int REG_BASE = NSRC + 1;
  localparam int IDX_W    = $clog2(SPUR_OFS + 1);
  // bit positions inside a source register
  localparam int EN_BIT   = LVL_W;
  localparam int SET_BIT  = 5;
  localparam int LIVE_BIT = 6;
  localparam int ACK_BIT  = 7;
  localparam int GEN_BIT  = 4;

  typedef struct packed {
    logic [NSRC-1:0]   srcWr;
    logic              genWr;
    logic              baseWr;
    logic [DATA_W-1:0] wrData;
  } vicStrobe_t;
endpackage

// File: rtl/vic_resolve.sv
module vic_resolve
  import vic_pkg::*;
(
  input  logic [NSRC-1:0]            eligible,
  input  logic [NSRC-1:0][LVL_W-1:0] levels,
  input  logic [LVL_W-1:0]           ackLevel,
  output logic [LVL_W-1:0]           topLevel,
  output logic                       hit,
  output logic [IDX_W-1:0]           hitIdx
);
  // highest level; strict compare keeps the first (lowest) index
  always_comb begin
    topLevel = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (eligible[i] && (levels[i] > topLevel)) topLevel = levels[i];
    end
  end

  // lowest index at the acknowledged level: scan downward, last match wins
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (eligible[i] && (levels[i] == ackLevel)) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  input  logic [NSRC-1:0][DATA_W-1:0] srcView,
  input  logic [DATA_W-1:0]           genView,
  input  logic [DATA_W-1:0]           baseView,
  output logic [DATA_W-1:0]           regRdData,
  output vicStrobe_t                  strb
);
  always_comb begin
    strb        = '0;
    strb.wrData = regWrData;
    for (int i = 0; i < NSRC; i++) begin
      if (regAddr == ADDR_W'(i)) strb.srcWr[i] = regWrEn;
    end
    strb.genWr  = regWrEn && (regAddr == ADDR_W'(REG_GEN));
    strb.baseWr = regWrEn && (regAddr == ADDR_W'(REG_BASE));
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (regAddr == ADDR_W'(i)) regRdData = srcView[i];
    end
    if (regAddr == ADDR_W'(REG_GEN))  regRdData = genView;
    if (regAddr == ADDR_W'(REG_BASE)) regRdData = baseView;
  end

  // R11
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.srcWr, strb.genWr, strb.baseWr}));
endmodule

// File: rtl/vic_dp.sv
module vic_dp
  import vic_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  vicStrobe_t                  strb,
  input  logic [NSRC-1:0]             hwIn,
  input  logic                        abortSw,
  input  logic                        ackValid,
  input  logic [LVL_W-1:0]            ackLevel,
  output logic [LVL_W-1:0]            irqLevel,
  output logic [DATA_W-1:0]           ackVector,
  output logic [NSRC-1:0][DATA_W-1:0] srcView,
  output logic [DATA_W-1:0]           genView,
  output logic [DATA_W-1:0]           baseView
);
  logic [NSRC-1:0]            rawIn, prevIn, hwEdge, ignoredIn;
  logic [NSRC-1:0]            pending, enable, eligible, setEv, clrEv;
  logic [NSRC-1:0][LVL_W-1:0] levels;
  logic                       genEn;
  logic [DATA_W-1:0]          baseReg;
  logic                       hit;
  logic [IDX_W-1:0]           hitIdx;
  logic                       unusedBits;

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= rawIn;
  end
  assign hwEdge = rawIn & ~prevIn;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam bit IS_ABORT = (i == ABORT_IDX);
    localparam bit IS_SW    = (i == SWA_IDX) || (i == SWB_IDX);

    if (IS_ABORT) begin : g_abort
      assign rawIn[i]     = abortSw;
      assign ignoredIn[i] = hwIn[i];
    end else if (IS_SW) begin : g_sw
      assign rawIn[i]     = 1'b0;
      assign ignoredIn[i] = hwIn[i];
    end else begin : g_hw
      assign rawIn[i]     = hwIn[i];
      assign ignoredIn[i] = 1'b0;
    end

    assign clrEv[i] = strb.srcWr[i] && strb.wrData[ACK_BIT];
    if (IS_SW) begin : g_swset
      assign setEv[i] = strb.srcWr[i] && strb.wrData[SET_BIT] && !strb.wrData[ACK_BIT];
    end else begin : g_hwset
      assign setEv[i] = hwEdge[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pending[i] <= 1'b0;
        enable[i]  <= 1'b0;
        levels[i]  <= '0;
      end else begin
        if (setEv[i])      pending[i] <= 1'b1;
        else if (clrEv[i]) pending[i] <= 1'b0;
        if (strb.srcWr[i]) begin
          enable[i] <= strb.wrData[EN_BIT];
          levels[i] <= strb.wrData[LVL_W-1:0];
        end
      end
    end

    assign eligible[i] = pending[i] && enable[i] && (levels[i] != '0) && genEn;

    always_comb begin
      srcView[i]              = '0;
      srcView[i][LVL_W-1:0]   = levels[i];
      srcView[i][EN_BIT]      = enable[i];
      srcView[i][ACK_BIT]     = pending[i];
      srcView[i][LIVE_BIT]    = IS_ABORT ? abortSw : 1'b0;
    end

    // R2
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
      hwEdge[i] |=> pending[i]);
    // R9
    ack_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pending[i] && !clrEv[i]) |=> pending[i]);
    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clrEv[i] && !hwEdge[i]) |=> !pending[i]);
  end

  assign unusedBits = ^{ignoredIn, strb.wrData[LIVE_BIT]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      genEn   <= 1'b0;
      baseReg <= '0;
    end else begin
      if (strb.genWr)  genEn   <= strb.wrData[GEN_BIT];
      if (strb.baseWr) baseReg <= strb.wrData;
    end
  end

  always_comb begin
    genView          = '0;
    genView[GEN_BIT] = genEn;
  end
  assign baseView = baseReg;

  vic_resolve i_resolve (
    .eligible (eligible),
    .levels   (levels),
    .ackLevel (ackLevel),
    .topLevel (irqLevel),
    .hit      (hit),
    .hitIdx   (hitIdx)
  );

  assign ackVector = !ackValid ? '0 :
                     baseReg + (hit ? DATA_W'(hitIdx) : DATA_W'(SPUR_OFS));

  // R5
  gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !genEn |-> (irqLevel == '0));
  // R5
  level_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != '0) |-> ((pending & enable) != '0));
  // R7
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && (irqLevel != '0) && (ackLevel == irqLevel))
      |-> (DATA_W'(ackVector - baseReg) < DATA_W'(NSRC)));
  // R8
  spur_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && (ackLevel == '0)) |-> (ackVector == DATA_W'(baseReg + DATA_W'(SPUR_OFS))));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic              abortSw,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              ackValid,
  input  logic [LVL_W-1:0]  ackLevel,
  output logic [DATA_W-1:0] ackVector,
  output logic [LVL_W-1:0]  irqLevel
);
  vicStrobe_t                  strb;
  logic [NSRC-1:0][DATA_W-1:0] srcView;
  logic [DATA_W-1:0]           genView, baseView;

  vic_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .srcView   (srcView),
    .genView   (genView),
    .baseView  (baseView),
    .regRdData (regRdData),
    .strb      (strb)
  );

  vic_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hwIn      (srcIn),
    .abortSw   (abortSw),
    .ackValid  (ackValid),
    .ackLevel  (ackLevel),
    .irqLevel  (irqLevel),
    .ackVector (ackVector),
    .srcView   (srcView),
    .genView   (genView),
    .baseView  (baseView)
  );
endmodule

// File: tb/test_vic_top.sv
module test_vic_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] srcIn = '0;
  logic        abortSw = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        ackValid = 1'b0;
  logic [2:0]  ackLevel = '0;
  logic [7:0]  ackVector;
  logic [2:0]  irqLevel;
  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  vic_top i_vic_top (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .abortSw(abortSw),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ackValid(ackValid), .ackLevel(ackLevel),
    .ackVector(ackVector), .irqLevel(irqLevel)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int addr, input int data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 5'(addr); regWrData = 8'(data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input int addr, input int exp);
    regAddr = 5'(addr);
    #1;
    check(tag, int'(regRdData), exp);
  endtask

  task automatic ackCheck(input string tag, input int lvl, input int exp);
    ackValid = 1'b1; ackLevel = 3'(lvl);
    #1;
    check(tag, int'(ackVector), exp);
    ackValid = 1'b0;
    #1;
  endtask

  task automatic pulse(input logic [11:0] bits);
    @(negedge clk); srcIn = bits;
    @(negedge clk); srcIn = '0;
  endtask

  task automatic cleanAll();
    for (int i = 0; i < 12; i++) wrReg(i, 8'h80);
    wrReg(12, 0);
  endtask

  task automatic tReset();
    check("R1 irqLevel", int'(irqLevel), 0);
    rdCheck("R1 gen", 12, 0);
    rdCheck("R1 base", 13, 0);
    rdCheck("R1 src4", 4, 0);
    rdCheck("R1 abort", 2, 0);
  endtask

  task automatic tEdge();
    pulse(12'h010);
    rdCheck("R2 pending while disabled", 4, 8'h80);
    check("R2 gate off", int'(irqLevel), 0);
    wrReg(12, 8'h10);
    check("R5 disabled source", int'(irqLevel), 0);
    wrReg(4, 8'h0D);
    rdCheck("R3 bit7=0 keeps", 4, 8'h8D);
    check("R5 level", int'(irqLevel), 5);
    @(negedge clk); srcIn[1] = 1'b1;
    @(negedge clk);
    rdCheck("R2 held level sets", 1, 8'h80);
    wrReg(1, 8'h80);
    rdCheck("R2 held level no rearm", 1, 8'h00);
    srcIn[1] = 1'b0;
  endtask

  task automatic tClear();
    wrReg(4, 8'h8D);
    rdCheck("R3 clear", 4, 8'h0D);
    check("R3 irq after clear", int'(irqLevel), 0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 5'd4; regWrData = 8'h8D; srcIn[4] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; srcIn[4] = 1'b0;
    rdCheck("R3 edge beats clear", 4, 8'h8D);
    check("R3 irq edge wins", int'(irqLevel), 5);
    cleanAll();
  endtask

  task automatic tSoft();
    wrReg(12, 8'h10);
    pulse(12'hC00);
    rdCheck("R4 srcIn ignored", 10, 8'h00);
    wrReg(10, 8'h2B);
    rdCheck("R4 soft set", 10, 8'h8B);
    check("R4 irq 3", int'(irqLevel), 3);
    wrReg(11, 8'h2E);
    check("R4 irq 6", int'(irqLevel), 6);
    wrReg(11, 8'h80);
    check("R4 back to 3", int'(irqLevel), 3);
    wrReg(10, 8'hAB);
    rdCheck("R4 clear wins", 10, 8'h0B);
    cleanAll();
  endtask

  task automatic tPrio();
    wrReg(13, 8'h40);
    wrReg(12, 8'h10);
    wrReg(3, 8'h0A);
    wrReg(7, 8'h0E);
    wrReg(9, 8'h0E);
    wrReg(5, 8'h07);
    wrReg(6, 8'h08);
    pulse(12'h2E8);
    check("R5 max level", int'(irqLevel), 6);
    ackCheck("R6 tie lower index", 6, 8'h47);
    ackCheck("R7 level 2", 2, 8'h43);
    wrReg(7, 8'h8E);
    check("R5 after clear", int'(irqLevel), 6);
    ackCheck("R7 next winner", 6, 8'h49);
    ackCheck("R8 disabled lvl7", 7, 8'h4F);
    wrReg(12, 8'h00);
    check("R5 gate off", int'(irqLevel), 0);
    ackCheck("R8 gate off", 6, 8'h4F);
    wrReg(12, 8'h10);
  endtask

  task automatic tSpur();
    ackCheck("R8 empty level", 4, 8'h4F);
    ackCheck("R8 level 0", 0, 8'h4F);
    ackLevel = 3'd6; #1;
    check("R7 idle zero", int'(ackVector), 0);
  endtask

  task automatic tAckKeep();
    @(negedge clk); ackValid = 1'b1; ackLevel = 3'd6;
    @(negedge clk); ackValid = 1'b0;
    rdCheck("R9 pending kept", 9, 8'h8E);
    check("R9 irq kept", int'(irqLevel), 6);
  endtask

  task automatic tAbort();
    cleanAll();
    @(negedge clk); abortSw = 1'b1;
    @(negedge clk);
    rdCheck("R10 live+pending", 2, 8'hC0);
    abortSw = 1'b0;
    rdCheck("R10 live low", 2, 8'h80);
    wrReg(2, 8'h80);
    pulse(12'h004);
    rdCheck("R10 srcIn2 ignored", 2, 8'h00);
  endtask

  task automatic tMap();
    wrReg(12, 8'hFF);
    rdCheck("R11 gen bits", 12, 8'h10);
    wrReg(20, 8'hFF);
    rdCheck("R11 unmapped", 20, 0);
    rdCheck("R11 base untouched", 13, 8'h40);
    rdCheck("R11 addr14", 14, 0);
    wrReg(0, 8'h7F);
    rdCheck("R11 src bits", 0, 8'h0F);
  endtask

  task automatic tWrap();
    cleanAll();
    wrReg(12, 8'h10);
    wrReg(13, 8'hF8);
    wrReg(9, 8'h09);
    pulse(12'h200);
    ackCheck("R12 wrap hit", 1, 8'h01);
    ackCheck("R12 wrap spurious", 3, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEdge();
    tClear();
    tSoft();
    tPrio();
    tSpur();
    tAckKeep();
    tAbort();
    tMap();
    tWrap();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule